// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a control write transfer on endpoint 0 of a USB device. A packet engine supplies decoded token pulses (SETUP, OUT, IN), the received bytes of data packets with an end-of-packet marker and a good-packet flag, and a pulse when the host acknowledges a packet the device sent. A local CPU writes a small set of registers. The block walks through idle, setup, data and status stages. It tells the packet engine to answer a token with a NAK or with a zero-length data packet, and it keeps a data-ready flag for the CPU.

A SETUP token starts the setup stage in any stage, so a new request aborts the current transfer. A correct 8-byte request moves the sequencer to the data stage, raises a setup interrupt and makes the request visible as five plain fields. OUT data is accepted only after the CPU has acknowledged the request and has drained the previous packet. The status stage begins when the CPU signals end of data. It ends with a zero-length IN reply, and a status interrupt follows when the host acknowledges that reply.

Each interrupt is a one-cycle pulse. It is also held in a status bit that the CPU clears by writing 1.

Top module: `ctrl_stage_seq`

## Requirements
- R1: The `stage` output encodes idle=0, setup=1, data=2, status=3. A `tokSetup` pulse while idle gives `stage`=1 on the next cycle.
- R2: In the setup stage, an `rxEnd` with `rxGood`=1 after exactly 8 bytes moves `stage` to 2 and gives a one-cycle `irqSetup` pulse in that same cycle. Any other ending (bad packet, fewer or more than 8 bytes) returns `stage` to 0 with no interrupt.
- R3: On a good request, byte 0 goes to `reqType` and byte 1 to `reqCode`. Bytes 2/3, 4/5 and 6/7 go to `reqValue`, `reqIndex` and `reqLength`, with the lower byte as the low half. A rejected request leaves all five fields unchanged.
- R4: A CPU write to address 0 acknowledges the request. In the data stage an OUT token gives a `sendNak` pulse on the next cycle until that write has happened.
- R5: An accepted OUT packet that ends with `rxGood`=1 sets `dataSet`. A CPU write to address 1 with bit 0 set clears it. A packet whose OUT token was NAKed does not set it.
- R6: An OUT token in the data stage while `dataSet` is 1 gives a `sendNak` pulse.
- R7: A CPU write to address 2 with bit 0 = 0 in the data stage moves `stage` to 3. The same write with bit 0 = 1 leaves `stage` at 2.
- R8: An IN token in the data stage gives a `sendNak` pulse and no `sendZlp`.
- R9: An IN token in the status stage gives a one-cycle `sendZlp` pulse, and `stage` returns to 0 in the same cycle.
- R10: An `hsAck` after that zero-length reply gives a one-cycle `irqStatus` pulse on the next cycle. An `hsAck` at any other time gives none.
- R11: `intStat` bit 0 latches the setup interrupt and bit 1 latches the status interrupt. A CPU write to address 3 clears each bit written as 1 and leaves the others. A set in the same cycle wins over a clear.
- R12: A SETUP token in the data or status stage gives `stage`=1 on the next cycle, clears `dataSet`, and withdraws the request acknowledge.
- R13: OUT and IN tokens in the idle stage produce neither `sendNak` nor `sendZlp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tokSetup | input | 1 | SETUP token pulse for endpoint 0 |
| tokOut | input | 1 | OUT token pulse for endpoint 0 |
| tokIn | input | 1 | IN token pulse for endpoint 0 |
| rxValid | input | 1 | Received data byte strobe |
| rxData | input | 8 | Received data byte |
| rxEnd | input | 1 | End of the received data packet |
| rxGood | input | 1 | Packet that ends now passed its checks |
| hsAck | input | 1 | Host ACK for the packet the device sent |
| cpuWrEn | input | 1 | CPU register write strobe |
| cpuAddr | input | 2 | CPU register address |
| cpuWrData | input | 8 | CPU write data |
| stage | output | 2 | Current stage |
| sendNak | output | 1 | Answer the last token with NAK |
| sendZlp | output | 1 | Answer the last token with a zero-length packet |
| irqSetup | output | 1 | Setup interrupt pulse |
| irqStatus | output | 1 | Status interrupt pulse |
| intStat | output | 2 | Latched interrupts, write 1 to clear |
| dataSet | output | 1 | OUT data waiting for the CPU |
| reqType | output | 8 | Request type field |
| reqCode | output | 8 | Request code field |
| reqValue | output | 16 | Request value field |
| reqIndex | output | 16 | Request index field |
| reqLength | output | 16 | Request length field |

## Verification
The bench sends requests that have a bad check, seven bytes or nine bytes. A design that counted badly or ignored `rxGood` would enter the data stage and show corrupted fields, or would overwrite fields that a good request had set earlier. It sends OUT tokens before the request acknowledge and while data is still pending, where a missing NAK would let the packet engine overwrite FIFO data the CPU has not read. It also writes the end-of-data register with the wrong bit value, aborts with a SETUP token while data is pending, and sends a stray host ACK. A design that got these wrong would reach the status stage early, keep a stale `dataSet` into the next request, or raise a status interrupt with no zero-length reply behind it.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int SETUP_BYTES = 8;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int IRQ_N       = 2;
  localparam int CNT_W       = $clog2(SETUP_BYTES + 1) + 1;
  localparam int IDX_W       = $clog2(SETUP_BYTES);

  localparam logic [ADDR_W-1:0] REG_REQ_ACK  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_DATA_CLR = 2'd1;
  localparam logic [ADDR_W-1:0] REG_EOP      = 2'd2;
  localparam logic [ADDR_W-1:0] REG_INT_CLR  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_DATA   = 2'd2,
    ST_STATUS = 2'd3
  } stage_t;

  // strobes from control to datapath
  typedef struct packed {
    logic abort;
    logic capture;
    logic commit;
    logic dataLoad;
    logic setSetupIrq;
    logic setStatusIrq;
  } ctl_strb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqAcked;
    logic dataSet;
    logic reqComplete;
    logic eopWrite;
  } dp_stat_t;
endpackage

// File: rtl/ctrl_seq_dp.sv
module ctrl_seq_dp
  import ctrl_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_strb_t              strb,
  input  logic                   rxValid,
  input  logic [BYTE_W-1:0]      rxData,
  input  logic                   cpuWrEn,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic [BYTE_W-1:0]      cpuWrData,
  output dp_stat_t               stat,
  output logic [IRQ_N-1:0]       intStat,
  output logic [BYTE_W-1:0]      reqType,
  output logic [BYTE_W-1:0]      reqCode,
  output logic [2*BYTE_W-1:0]    reqValue,
  output logic [2*BYTE_W-1:0]    reqIndex,
  output logic [2*BYTE_W-1:0]    reqLength
);
  logic [SETUP_BYTES-1:0][BYTE_W-1:0] reqBuf;
  logic [CNT_W-1:0] byteCnt;
  logic             reqAcked;
  logic             dataSetQ;
  logic [IRQ_N-1:0] irqSet;
  logic             unusedHi;

  assign unusedHi = ^cpuWrData[BYTE_W-1:IRQ_N];

  wire wrAck  = cpuWrEn && (cpuAddr == REG_REQ_ACK);
  wire wrDclr = cpuWrEn && (cpuAddr == REG_DATA_CLR) && cpuWrData[0];
  wire wrIclr = cpuWrEn && (cpuAddr == REG_INT_CLR);
  wire inRange = byteCnt < CNT_W'(SETUP_BYTES);

  // byte counter, saturating so over-long requests stay rejected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else if (strb.abort) byteCnt <= '0;
    else if (strb.capture && byteCnt != '1) byteCnt <= byteCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqBuf <= '0;
    else if (strb.capture && inRange) reqBuf[byteCnt[IDX_W-1:0]] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqType <= '0; reqCode <= '0;
      reqValue <= '0; reqIndex <= '0; reqLength <= '0;
    end else if (strb.commit) begin
      reqType   <= reqBuf[0];
      reqCode   <= reqBuf[1];
      reqValue  <= {reqBuf[3], reqBuf[2]};
      reqIndex  <= {reqBuf[5], reqBuf[4]};
      reqLength <= {reqBuf[7], reqBuf[6]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqAcked <= 1'b0;
    else if (strb.abort) reqAcked <= 1'b0;
    else if (wrAck) reqAcked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataSetQ <= 1'b0;
    else if (strb.abort) dataSetQ <= 1'b0;
    else if (strb.dataLoad) dataSetQ <= 1'b1;
    else if (wrDclr) dataSetQ <= 1'b0;
  end

  assign irqSet = {strb.setStatusIrq, strb.setSetupIrq};

  for (genvar g = 0; g < IRQ_N; g++) begin : g_irqLatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) intStat[g] <= 1'b0;
      else if (irqSet[g]) intStat[g] <= 1'b1;
      else if (wrIclr && cpuWrData[g]) intStat[g] <= 1'b0;
    end
  end

  assign stat.reqAcked    = reqAcked;
  assign stat.dataSet     = dataSetQ;
  assign stat.reqComplete = (byteCnt == CNT_W'(SETUP_BYTES));
  assign stat.eopWrite    = cpuWrEn && (cpuAddr == REG_EOP) && !cpuWrData[0];
endmodule

// File: rtl/ctrl_seq_ctl.sv
module ctrl_seq_ctl
  import ctrl_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tokSetup,
  input  logic      tokOut,
  input  logic      tokIn,
  input  logic      rxValid,
  input  logic      rxEnd,
  input  logic      rxGood,
  input  logic      hsAck,
  input  dp_stat_t  stat,
  output stage_t    stage,
  output ctl_strb_t strb,
  output logic      sendNak,
  output logic      sendZlp,
  output logic      irqSetup,
  output logic      irqStatus
);
  stage_t stageNext;
  logic   outOpen, outOpenNext;
  logic   zlpWait, zlpWaitNext;
  logic   nakNext, zlpNext;

  always_comb begin
    stageNext   = stage;
    outOpenNext = outOpen;
    zlpWaitNext = zlpWait;
    nakNext     = 1'b0;
    zlpNext     = 1'b0;
    strb        = '0;
    strb.capture = (stage == ST_SETUP) && rxValid;
    if (tokSetup) begin
      stageNext   = ST_SETUP;
      strb.abort  = 1'b1;
      outOpenNext = 1'b0;
      zlpWaitNext = 1'b0;
    end else begin
      case (stage)
        ST_SETUP: begin
          if (rxEnd) begin
            if (rxGood && stat.reqComplete) begin
              stageNext        = ST_DATA;
              strb.commit      = 1'b1;
              strb.setSetupIrq = 1'b1;
            end else begin
              stageNext = ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (tokOut) begin
            if (stat.reqAcked && !stat.dataSet) outOpenNext = 1'b1;
            else nakNext = 1'b1;
          end
          if (tokIn) nakNext = 1'b1;
          if (rxEnd && outOpen) begin
            outOpenNext   = 1'b0;
            strb.dataLoad = rxGood;
          end
          if (stat.eopWrite) begin
            stageNext   = ST_STATUS;
            outOpenNext = 1'b0;
          end
        end
        ST_STATUS: begin
          if (tokIn) begin
            zlpNext     = 1'b1;
            stageNext   = ST_IDLE;
            zlpWaitNext = 1'b1;
          end
          if (tokOut) nakNext = 1'b1;
        end
        default: ;
      endcase
      if (hsAck && zlpWait) begin
        strb.setStatusIrq = 1'b1;
        zlpWaitNext       = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage     <= ST_IDLE;
      outOpen   <= 1'b0;
      zlpWait   <= 1'b0;
      sendNak   <= 1'b0;
      sendZlp   <= 1'b0;
      irqSetup  <= 1'b0;
      irqStatus <= 1'b0;
    end else begin
      stage     <= stageNext;
      outOpen   <= outOpenNext;
      zlpWait   <= zlpWaitNext;
      sendNak   <= nakNext;
      sendZlp   <= zlpNext;
      irqSetup  <= strb.setSetupIrq;
      irqStatus <= strb.setStatusIrq;
    end
  end
endmodule

// File: rtl/ctrl_stage_seq.sv
module ctrl_stage_seq
  import ctrl_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tokSetup,
  input  logic                tokOut,
  input  logic                tokIn,
  input  logic                rxValid,
  input  logic [BYTE_W-1:0]   rxData,
  input  logic                rxEnd,
  input  logic                rxGood,
  input  logic                hsAck,
  input  logic                cpuWrEn,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [BYTE_W-1:0]   cpuWrData,
  output logic [1:0]          stage,
  output logic                sendNak,
  output logic                sendZlp,
  output logic                irqSetup,
  output logic                irqStatus,
  output logic [IRQ_N-1:0]    intStat,
  output logic                dataSet,
  output logic [BYTE_W-1:0]   reqType,
  output logic [BYTE_W-1:0]   reqCode,
  output logic [2*BYTE_W-1:0] reqValue,
  output logic [2*BYTE_W-1:0] reqIndex,
  output logic [2*BYTE_W-1:0] reqLength
);
  ctl_strb_t strb;
  dp_stat_t  stat;
  stage_t    stageQ;

  ctrl_seq_ctl i_ctl (
    .clk(clk), .rstN(rstN),
    .tokSetup(tokSetup), .tokOut(tokOut), .tokIn(tokIn),
    .rxValid(rxValid), .rxEnd(rxEnd), .rxGood(rxGood), .hsAck(hsAck),
    .stat(stat), .stage(stageQ), .strb(strb),
    .sendNak(sendNak), .sendZlp(sendZlp),
    .irqSetup(irqSetup), .irqStatus(irqStatus)
  );

  ctrl_seq_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxValid(rxValid), .rxData(rxData),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .stat(stat), .intStat(intStat),
    .reqType(reqType), .reqCode(reqCode),
    .reqValue(reqValue), .reqIndex(reqIndex), .reqLength(reqLength)
  );

  assign stage   = stageQ;
  assign dataSet = stat.dataSet;
endmodule

// File: rtl/ctrl_seq_chk.sv
module ctrl_seq_chk
  import ctrl_seq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tokSetup,
  input logic               tokOut,
  input logic               tokIn,
  input logic               hsAck,
  input logic [1:0]         stage,
  input logic               sendNak,
  input logic               sendZlp,
  input logic               irqSetup,
  input logic               irqStatus,
  input logic [IRQ_N-1:0]   intStat,
  input logic               dataSet
);
  // R2
  setup_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqSetup |=> !irqSetup);

  // R2
  setup_irq_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqSetup |-> stage == 2'd2);

  // R11
  setup_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqSetup |-> intStat[0]);

  // R9
  zlp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendZlp |-> (stage == 2'd0 && $past(stage) == 2'd3));

  // R10
  status_irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus |-> $past(hsAck));

  // R12
  setup_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    tokSetup |=> (stage == 2'd1 && !dataSet));

  // R6
  out_hold_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 2'd2 && tokOut && dataSet && !tokSetup) |=> sendNak);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 2'd0 && !tokSetup) |=> !sendNak && !sendZlp);
endmodule

bind ctrl_stage_seq ctrl_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .tokSetup(tokSetup), .tokOut(tokOut), .tokIn(tokIn),
  .hsAck(hsAck), .stage(stage), .sendNak(sendNak), .sendZlp(sendZlp),
  .irqSetup(irqSetup), .irqStatus(irqStatus), .intStat(intStat), .dataSet(dataSet)
);

// File: tb/test_ctrl_stage_seq.sv
module test_ctrl_stage_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokSetup = 0, tokOut = 0, tokIn = 0, rxValid = 0, rxEnd = 0, rxGood = 0, hsAck = 0;
  logic [7:0] rxData = '0;
  logic cpuWrEn = 0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic [1:0] stage;
  logic sendNak, sendZlp, irqSetup, irqStatus, dataSet;
  logic [1:0] intStat;
  logic [7:0] reqType, reqCode;
  logic [15:0] reqValue, reqIndex, reqLength;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_stage_seq i_ctrl_stage_seq (.*);

  localparam logic [63:0] REQ_VEC [4] = '{
    64'h0040_0000_0003_0921, 64'h0008_0001_0305_A340,
    64'h1234_ABCD_5678_9A41, 64'hFFFF_0000_0000_0102 };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    {tokSetup, tokOut, tokIn, rxValid, rxEnd, rxGood, hsAck, cpuWrEn} = '0;
  endtask

  task automatic tok(input int kind);
    if (kind == 0) tokSetup = 1; else if (kind == 1) tokOut = 1; else tokIn = 1;
    cyc();
  endtask

  task automatic pkt(input logic [63:0] bytes, input int n, input bit good);
    for (int i = 0; i < n; i++) begin
      rxValid = 1; rxData = bytes[8*(i%8) +: 8];
      cyc();
    end
    rxEnd = 1; rxGood = good;
    cyc();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpuWrEn = 1; cpuAddr = a; cpuWrData = d;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc();
    chk("R1 reset stage", stage, 0);
    chk("R5 reset dataSet", dataSet, 0);
    chk("R11 reset intStat", intStat, 0);
    chk("R2 reset irq", {irqSetup, irqStatus, sendNak, sendZlp}, 0);

    foreach (REQ_VEC[v]) begin
      tok(0);
      chk("R1 setup stage", stage, 1);
      pkt(REQ_VEC[v], 8, 1);
      chk("R2 data stage", stage, 2);
      chk("R2 irqSetup pulse", irqSetup, 1);
      chk("R11 setup latched", intStat[0], 1);
      chk("R3 reqType", reqType, REQ_VEC[v][7:0]);
      chk("R3 reqCode", reqCode, REQ_VEC[v][15:8]);
      chk("R3 reqValue", reqValue, REQ_VEC[v][31:16]);
      chk("R3 reqIndex", reqIndex, REQ_VEC[v][47:32]);
      chk("R3 reqLength", reqLength, REQ_VEC[v][63:48]);
      wr(2'd0, 8'h00);
      chk("R2 irqSetup single", irqSetup, 0);
      tok(1);
      chk("R4 OUT accepted after ack", sendNak, 0);
      pkt(~REQ_VEC[v], 4, 1);
      chk("R5 dataSet set", dataSet, 1);
      tok(1);
      chk("R6 OUT NAK while dataSet", sendNak, 1);
      wr(2'd1, 8'h01);
      chk("R5 dataSet cleared", dataSet, 0);
      tok(2);
      chk("R8 IN NAK in data", {sendNak, sendZlp}, 2'b10);
      wr(2'd2, 8'h00);
      chk("R7 status stage", stage, 3);
      tok(2);
      chk("R9 zlp", sendZlp, 1);
      chk("R9 back to idle", stage, 0);
      hsAck = 1; cyc();
      chk("R10 irqStatus", irqStatus, 1);
      chk("R11 status latched", intStat, 2'b11);
      cyc();
      chk("R10 irqStatus single", irqStatus, 0);
      wr(2'd3, 8'h03);
      chk("R11 W1C all", intStat, 0);
    end

    // rejected requests keep earlier fields
    tok(0); pkt(64'h1111_2222_3333_4444, 8, 0);
    chk("R2 bad check to idle", stage, 0);
    chk("R2 no irq on bad", intStat[0], 0);
    chk("R3 fields kept", reqLength, 16'hFFFF);
    tok(0); pkt(64'h1111_2222_3333_4444, 7, 1);
    chk("R2 short to idle", stage, 0);
    tok(0); pkt(64'h1111_2222_3333_4444, 9, 1);
    chk("R2 long to idle", stage, 0);
    chk("R3 fields kept long", reqType, 8'h02);

    // OUT before request acknowledge
    tok(0); pkt(REQ_VEC[0], 8, 1);
    tok(1);
    chk("R4 OUT NAK before ack", sendNak, 1);
    pkt(64'h55, 2, 1);
    chk("R5 NAKed data ignored", dataSet, 0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    chk("R7 eop bit set ignored", stage, 2);
    tok(1); pkt(64'h66, 2, 1);
    chk("R5 dataSet after ack", dataSet, 1);
    tok(0);
    chk("R12 abort stage", stage, 1);
    chk("R12 abort clears dataSet", dataSet, 0);
    pkt(REQ_VEC[1], 8, 1);
    tok(1);
    chk("R12 ack withdrawn", sendNak, 1);

    // partial clear, stray ack, idle tokens
    wr(2'd3, 8'h01);
    chk("R11 partial W1C", intStat, 2'b00);
    tok(0); pkt(REQ_VEC[2], 8, 1);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); tok(2); hsAck = 1; cyc();
    wr(2'd3, 8'h01);
    chk("R11 W1C only bit0", intStat, 2'b10);
    hsAck = 1; cyc();
    chk("R10 stray ack ignored", irqStatus, 0);
    tok(1);
    chk("R13 OUT idle quiet", {sendNak, sendZlp}, 0);
    tok(2);
    chk("R13 IN idle quiet", {sendNak, sendZlp}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule